// File: doc/BRIEF.md
# Framed Serial Control Register Receiver

This block holds a six-bit control word for a converter front end: a three-bit channel address, a software conversion-start bit, a standby bit and an output-format bit. The word arrives over a three-wire framed link driven by an external master. The link carries a serial clock, an active-low frame strobe and a data line. The serial clock and the strobe run asynchronously to the system clock. Each of the three lines passes through a two-flop synchronizer, and the block detects the edges of the synchronized lines in the system clock domain.

A word is committed only when its sixth bit has been captured inside a frame. A frame that closes before six bits arrive leaves the register untouched and raises an abort pulse. If the software start bit is already set when that happens, the block also asks for a new conversion. A parallel write port is a second way to load the register. Each load reports a one-cycle commit pulse with a flag that tells whether the address field was written. All event outputs are single-cycle pulses and have no back-pressure: downstream logic cannot stall them and must take each pulse in the cycle it appears.

Top module: `ser_ctl_rx`

## Requirements
- R1: After reset all six control bits read 0, and no commit, abort or conversion pulse is produced until traffic arrives.
- R2: A frame with six falling serial clock edges loads the register. The first bit goes to address bit 2 (MSB), then address bit 1, address bit 0, software start, standby and format, in that order. A commit pulse is raised with the address flag set to 1.
- R3: Falling edges after the sixth, while the strobe is still low, are ignored and do not change the register.
- R4: A frame that ends with fewer than six falling edges, including zero, leaves the register unchanged, produces an abort pulse and produces no commit pulse.
- R5: An aborted frame raises a conversion request if the stored software start bit is 1, and raises none if that bit is 0.
- R6: A committed word whose software start bit is 1 raises a conversion request in the same cycle as its commit pulse.
- R7: A parallel write loads par_data, with bits [5:3] as the address, [2] software start, [1] standby and [0] format. When par_addr_en is 0, the stored address is kept. The write gives a commit pulse whose address flag equals par_addr_en. A serial commit or abort in the same cycle takes precedence, and the parallel write is then dropped.
- R8: Serial clock edges while the strobe is high are ignored: they neither change the register nor count toward the next frame.
- R9: Commit, abort and conversion pulses last exactly one system clock cycle for each event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | External serial clock; bits are sampled on its falling edges |
| frame_n | input | 1 | Active-low frame strobe |
| ser_din | input | 1 | Serial data, MSB first |
| par_we | input | 1 | Parallel write strobe, one cycle |
| par_addr_en | input | 1 | Parallel write also updates the address field |
| par_data | input | 6 | Parallel control word |
| ctl_addr | output | 3 | Stored channel address |
| ctl_swstart | output | 1 | Stored software start bit |
| ctl_standby | output | 1 | Stored standby bit |
| ctl_twos | output | 1 | Stored format bit (1 = twos complement) |
| commit_pulse | output | 1 | One-cycle pulse when the register is loaded |
| commit_addr_wr | output | 1 | Address field was written by this commit |
| abort_pulse | output | 1 | One-cycle pulse when a frame ends short |
| conv_req | output | 1 | One-cycle conversion request |

## Verification
The hardest case to reach is a short frame that arrives while the stored software start bit is already 1. The bench first commits a full word with that bit set, then sends a five-bit frame, and checks three results: an abort pulse, a conversion request, and a register that still holds the old word. A second hard case is serial clock activity outside a frame. The bench toggles the serial clock with the strobe high, then sends a clean six-bit frame. A correctly decoded word shows that the idle edges were never counted.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  localparam int CTL_ADDR_W = 3;

  typedef struct packed {
    logic [CTL_ADDR_W-1:0] addr;
    logic                  swstart;
    logic                  standby;
    logic                  twos;
  } ctl_word_t;

  localparam int CTL_WORD_W = $bits(ctl_word_t);
endpackage

// File: rtl/ctl_sync.sv
module ctl_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ctl_frame_rx.sv
module ctl_frame_rx #(
  parameter int WORD_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              frame_s,
  input  logic              din_s,
  output logic              done,
  output logic [WORD_W-1:0] word,
  output logic              short_end
);
  localparam int               CNT_W = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(WORD_W);

  logic              sclk_d, frame_d;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] shreg;
  logic              fall, rise, in_frame, take;

  assign fall     = sclk_d & ~sclk_s;
  assign rise     = ~frame_d & frame_s;
  assign in_frame = ~frame_s;
  assign take     = fall & in_frame & (cnt < FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b1;
      frame_d <= 1'b1;
      cnt     <= '0;
      shreg   <= '0;
    end else begin
      sclk_d  <= sclk_s;
      frame_d <= frame_s;
      if (!in_frame) begin
        cnt <= '0;
      end else if (take) begin
        cnt   <= cnt + 1'b1;
        shreg <= {shreg[WORD_W-2:0], din_s};
      end
    end
  end

  // Bits arrive MSB first, so the first bit ends up in the top position.
  assign word      = {shreg[WORD_W-2:0], din_s};
  assign done      = take & (cnt == LAST);
  assign short_end = rise & (cnt < FULL);
endmodule

// File: rtl/ctl_word_reg.sv
module ctl_word_reg
  import ctl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ser_done,
  input  ctl_word_t ser_word,
  input  logic      ser_short,
  input  logic      par_we,
  input  logic      par_addr_en,
  input  ctl_word_t par_word,
  output ctl_word_t ctl,
  output logic      commit,
  output logic      commit_addr,
  output logic      abort,
  output logic      conv_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl         <= '0;
      commit      <= 1'b0;
      commit_addr <= 1'b0;
      abort       <= 1'b0;
      conv_req    <= 1'b0;
    end else begin
      commit      <= 1'b0;
      commit_addr <= 1'b0;
      abort       <= 1'b0;
      conv_req    <= 1'b0;
      if (ser_done) begin
        ctl         <= ser_word;
        commit      <= 1'b1;
        commit_addr <= 1'b1;
        conv_req    <= ser_word.swstart;
      end else if (ser_short) begin
        abort    <= 1'b1;
        conv_req <= ctl.swstart;
      end else if (par_we) begin
        ctl.addr    <= par_addr_en ? par_word.addr : ctl.addr;
        ctl.swstart <= par_word.swstart;
        ctl.standby <= par_word.standby;
        ctl.twos    <= par_word.twos;
        commit      <= 1'b1;
        commit_addr <= par_addr_en;
        conv_req    <= par_word.swstart;
      end
    end
  end
endmodule

// File: rtl/ser_ctl_rx.sv
module ser_ctl_rx
  import ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ser_clk,
  input  logic                  frame_n,
  input  logic                  ser_din,
  input  logic                  par_we,
  input  logic                  par_addr_en,
  input  logic [CTL_WORD_W-1:0] par_data,
  output logic [CTL_ADDR_W-1:0] ctl_addr,
  output logic                  ctl_swstart,
  output logic                  ctl_standby,
  output logic                  ctl_twos,
  output logic                  commit_pulse,
  output logic                  commit_addr_wr,
  output logic                  abort_pulse,
  output logic                  conv_req
);
  logic [2:0]            sync_q;
  logic                  done, short_end;
  logic [CTL_WORD_W-1:0] word;
  ctl_word_t             ctl;

  // Bus order {data, strobe, clock}; strobe and clock idle high.
  ctl_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b011)) sync_i (
    .clk(clk), .rst_n(rst_n),
    .d({ser_din, frame_n, ser_clk}),
    .q(sync_q)
  );

  ctl_frame_rx #(.WORD_W(CTL_WORD_W)) frame_i (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sync_q[0]), .frame_s(sync_q[1]), .din_s(sync_q[2]),
    .done(done), .word(word), .short_end(short_end)
  );

  ctl_word_reg reg_i (
    .clk(clk), .rst_n(rst_n),
    .ser_done(done), .ser_word(ctl_word_t'(word)), .ser_short(short_end),
    .par_we(par_we), .par_addr_en(par_addr_en),
    .par_word(ctl_word_t'(par_data)),
    .ctl(ctl), .commit(commit_pulse), .commit_addr(commit_addr_wr),
    .abort(abort_pulse), .conv_req(conv_req)
  );

  assign ctl_addr    = ctl.addr;
  assign ctl_swstart = ctl.swstart;
  assign ctl_standby = ctl.standby;
  assign ctl_twos    = ctl.twos;
endmodule

// File: rtl/ser_ctl_rx_chk.sv
module ser_ctl_rx_chk (
  input logic                          clk,
  input logic                          rst_n,
  input logic [ctl_pkg::CTL_ADDR_W-1:0] ctl_addr,
  input logic                          ctl_swstart,
  input logic                          ctl_standby,
  input logic                          ctl_twos,
  input logic                          commit_pulse,
  input logic                          abort_pulse,
  input logic                          conv_req
);
  // R4
  reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |-> $stable({ctl_addr, ctl_swstart, ctl_standby, ctl_twos}));

  // R4
  commit_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_pulse && abort_pulse));

  // R5
  abort_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (abort_pulse && ctl_swstart) |-> conv_req);

  // R6
  commit_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && ctl_swstart) |-> conv_req);

  // R5
  conv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req |-> ((commit_pulse || abort_pulse) && ctl_swstart));

  // R9
  abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_pulse |=> !abort_pulse);
endmodule

bind ser_ctl_rx ser_ctl_rx_chk chk_i (
  .clk(clk), .rst_n(rst_n),
  .ctl_addr(ctl_addr), .ctl_swstart(ctl_swstart),
  .ctl_standby(ctl_standby), .ctl_twos(ctl_twos),
  .commit_pulse(commit_pulse), .abort_pulse(abort_pulse),
  .conv_req(conv_req)
);

// File: tb/ser_ctl_rx_tb_top.sv
module ser_ctl_rx_tb_top;
  localparam int CLK_P = 10;
  localparam int HALF  = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_clk = 1'b1, frame_n = 1'b1, ser_din = 1'b0;
  logic       par_we = 1'b0, par_addr_en = 1'b0;
  logic [5:0] par_data = '0;
  logic [2:0] ctl_addr;
  logic       ctl_swstart, ctl_standby, ctl_twos;
  logic       commit_pulse, commit_addr_wr, abort_pulse, conv_req;

  int n_chk = 0, n_bad = 0;
  int n_commit = 0, n_abort = 0, n_conv = 0;
  int run_c = 0, run_a = 0, run_v = 0, max_run = 0;
  logic last_flag = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  ser_ctl_rx dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .frame_n(frame_n),
    .ser_din(ser_din), .par_we(par_we), .par_addr_en(par_addr_en),
    .par_data(par_data), .ctl_addr(ctl_addr), .ctl_swstart(ctl_swstart),
    .ctl_standby(ctl_standby), .ctl_twos(ctl_twos),
    .commit_pulse(commit_pulse), .commit_addr_wr(commit_addr_wr),
    .abort_pulse(abort_pulse), .conv_req(conv_req)
  );

  always @(negedge clk) if (rst_n) begin
    if (commit_pulse) begin n_commit++; last_flag = commit_addr_wr; end
    if (abort_pulse) n_abort++;
    if (conv_req) n_conv++;
    run_c = commit_pulse ? run_c + 1 : 0;
    run_a = abort_pulse ? run_a + 1 : 0;
    run_v = conv_req ? run_v + 1 : 0;
    if (run_c > max_run) max_run = run_c;
    if (run_a > max_run) max_run = run_a;
    if (run_v > max_run) max_run = run_v;
  end

  function automatic logic [5:0] rd();
    return {ctl_addr, ctl_swstart, ctl_standby, ctl_twos};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // Sends nb bits of data, MSB first (bit nb-1 goes out first).
  task automatic send(input int nb, input logic [15:0] data);
    frame_n = 1'b0;
    wclk(HALF);
    for (int i = 0; i < nb; i++) begin
      ser_din = data[nb-1-i];
      wclk(HALF);
      ser_clk = 1'b0;
      wclk(HALF);
      ser_clk = 1'b1;
    end
    wclk(HALF);
    frame_n = 1'b1;
    wclk(8);
  endtask

  task automatic pwrite(input logic en, input logic [5:0] d);
    par_addr_en = en;
    par_data    = d;
    par_we      = 1'b1;
    wclk(1);
    par_we      = 1'b0;
    wclk(3);
  endtask

  task automatic t_reset();
    chk("R1 word", rd(), 0);
    chk("R1 pulses", n_commit + n_abort + n_conv, 0);
  endtask

  task automatic t_full();
    int c0 = n_commit, v0 = n_conv, a0 = n_abort;
    send(6, 16'b101011);
    chk("R2 word", rd(), 6'b101011);
    chk("R2 commit", n_commit - c0, 1);
    chk("R2 flag", last_flag, 1);
    chk("R2 no conv", n_conv - v0, 0);
    chk("R2 no abort", n_abort - a0, 0);
    v0 = n_conv;
    send(6, 16'b010100);
    chk("R6 word", rd(), 6'b010100);
    chk("R6 conv", n_conv - v0, 1);
  endtask

  task automatic t_long();
    int c0 = n_commit;
    send(9, {7'b0, 6'b011001, 3'b111});
    chk("R3 word", rd(), 6'b011001);
    chk("R3 one commit", n_commit - c0, 1);
  endtask

  task automatic t_short();
    int c0 = n_commit, a0 = n_abort, v0 = n_conv;
    send(3, 16'b111);
    chk("R4 word kept", rd(), 6'b011001);
    chk("R4 abort", n_abort - a0, 1);
    chk("R4 no commit", n_commit - c0, 0);
    chk("R5 no conv sw0", n_conv - v0, 0);
    send(0, 16'b0);
    chk("R4 empty abort", n_abort - a0, 2);
    send(6, 16'b000100);
    a0 = n_abort; v0 = n_conv; c0 = n_commit;
    send(5, 16'b11011);
    chk("R5 word kept", rd(), 6'b000100);
    chk("R5 abort", n_abort - a0, 1);
    chk("R5 conv sw1", n_conv - v0, 1);
    chk("R5 no commit", n_commit - c0, 0);
  endtask

  task automatic t_idle();
    int c0 = n_commit, a0 = n_abort;
    ser_din = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wclk(HALF); ser_clk = 1'b0;
      wclk(HALF); ser_clk = 1'b1;
    end
    wclk(8);
    chk("R8 word kept", rd(), 6'b000100);
    chk("R8 no events", (n_commit - c0) + (n_abort - a0), 0);
    send(6, 16'b110010);
    chk("R8 next frame", rd(), 6'b110010);
  endtask

  task automatic t_par();
    int c0 = n_commit, v0 = n_conv;
    pwrite(1'b1, 6'b111001);
    chk("R7 word", rd(), 6'b111001);
    chk("R7 commit", n_commit - c0, 1);
    chk("R7 flag1", last_flag, 1);
    pwrite(1'b0, 6'b000110);
    chk("R7 addr kept", rd(), 6'b111110);
    chk("R7 flag0", last_flag, 0);
    chk("R7 conv", n_conv - v0, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wclk(4);
    rst_n = 1'b1;
    wclk(6);
    t_reset();
    t_full();
    t_long();
    t_short();
    t_idle();
    t_par();
    chk("R9 pulse width", max_run, 1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule